// File: doc/BRIEF.md
# Hierarchical Two-Level Barrier

This block joins a grid of cores at a hardware barrier using dedicated wires instead of network packets. Each core raises its arrival input when it reaches the synchronisation point and holds it there. The block then keeps that core waiting until every other core has done the same. Arrivals are first collected inside each row by a row gathering unit. Once a row is complete, that unit raises a completion request on a vertical line. A single combining unit watches all the vertical lines. When every row is complete, it drives one release acknowledge back down to all rows. Each row unit then raises the release output of every core in its row, so release travels the reverse path of arrival.

Every link is a four-phase request/acknowledge handshake. A core acknowledges its release by dropping its arrival input, and its release output falls on the next cycle. After all cores have acknowledged, the vertical handshakes return to idle. The barrier then re-arms by itself, so the cores can run one episode directly after another. The grid size is set by parameters; the default is 4 rows of 4 cores.

Top module: `bar_tree`

## Requirements
- R1: After reset every release output is low and the barrier is collecting arrivals.
- R2: No release output rises before all ROWS*COLS arrival inputs have been sampled high within the current arrival phase. A row reports completion only once all of its cores have arrived.
- R3: All release outputs rise in the same cycle, three clock edges after the edge that samples the last missing arrival.
- R4: A core's release output stays high while that core's arrival input is high. It falls on the edge that samples the arrival input low. Each core does this independently of the others.
- R5: The barrier re-arms without outside help. Arrivals are counted again from the fourth edge after the edge on which the last release output fell, and an arrival input held high across that point counts as one arrival of the new episode.
- R6: Suppose a core drops and re-raises its arrival input while other cores still hold their release. That core is counted once for the next episode, and the next release still waits for every other core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arrive_i | input | ROWS*COLS | Arrival request per core; bit index is row*COLS+column. A core keeps it high until it sees its release, then lowers it as acknowledge |
| release_o | output | ROWS*COLS | Release per core, same bit order as arrive_i |

## Verification
On every cycle, the assertions check the following. A row raises its vertical request only after its own arrival set is full. The combining unit acknowledges only when all row requests are up, and returns to idle only after all of them have dropped. A core's release rises only for a recorded arrival and falls only after that core has lowered its input. All releases appear together.

The exact three-edge latency, the re-arm point, and the handling of an early re-raise can only be shown by the bench scenarios. Those scenarios compare every output cycle against a timing model of the episodes.

// File: rtl/bar_pkg.sv
package bar_pkg;

    // State of one row gathering unit
    typedef enum logic [1:0] {
        ROW_GATHER  = 2'd0,  // collecting arrivals of the row
        ROW_WAIT    = 2'd1,  // vertical request up, waiting for acknowledge
        ROW_RELEASE = 2'd2,  // releases driven, waiting for core acknowledges
        ROW_DONE    = 2'd3   // vertical request down, waiting for acknowledge to drop
    } row_state_e;

    // State of the combining unit
    typedef enum logic {
        TOP_GATHER  = 1'b0,
        TOP_RELEASE = 1'b1
    } top_state_e;

    // Flags of one row as seen on the vertical line
    typedef struct packed {
        logic full;     // every core of the row recorded
        logic up_req;   // completion request towards the combining unit
    } row_flags_t;

    function automatic logic row_req_of(input row_state_e s);
        return (s == ROW_WAIT) || (s == ROW_RELEASE);
    endfunction

endpackage

// File: rtl/bar_row.sv
module bar_row
    import bar_pkg::*;
#(
    parameter int COLS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [COLS-1:0] arv_i,
    input  logic            go_i,
    output logic            done_o,
    output logic [COLS-1:0] rel_o
);

    row_state_e      st_q, st_d;
    logic [COLS-1:0] got_q;
    logic [COLS-1:0] rel_q;
    row_flags_t      flg;

    assign flg.full   = &got_q;
    assign flg.up_req = row_req_of(st_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ROW_GATHER:  if (flg.full) st_d = ROW_WAIT;
            ROW_WAIT:    if (go_i) st_d = ROW_RELEASE;
            ROW_RELEASE: if (~|rel_q) st_d = ROW_DONE;
            ROW_DONE:    if (!go_i) st_d = ROW_GATHER;
            default:     st_d = ROW_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ROW_GATHER;
            got_q <= '0;
            rel_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ROW_GATHER)
                got_q <= got_q | arv_i;
            else if (st_q == ROW_WAIT && go_i)
                got_q <= '0;
            if (st_q == ROW_WAIT && go_i)
                rel_q <= '1;
            else
                rel_q <= rel_q & arv_i;
        end
    end

    assign done_o = flg.up_req;
    assign rel_o  = rel_q;

    // R2
    row_full_before_up_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(done_o)) |-> $past(&got_q));

    for (genvar c = 0; c < COLS; c++) begin : g_core_chk
        // R2
        rel_needs_arrival_chk: assert property (@(posedge clk) disable iff (rst)
            (rel_o[c] && !$past(rel_o[c])) |-> ($past(got_q[c]) && $past(go_i)));
        // R4
        rel_drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
            (!rel_o[c] && $past(rel_o[c])) |-> !$past(arv_i[c]));
    end

endmodule

// File: rtl/bar_top_unit.sv
module bar_top_unit
    import bar_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ROWS-1:0] up_i,
    output logic            go_o
);

    top_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TOP_GATHER:  if (&up_i) st_d = TOP_RELEASE;
            TOP_RELEASE: if (~|up_i) st_d = TOP_GATHER;
            default:     st_d = TOP_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TOP_GATHER;
        else     st_q <= st_d;
    end

    assign go_o = (st_q == TOP_RELEASE);

    // R2
    go_after_all_rows_chk: assert property (@(posedge clk) disable iff (rst)
        (go_o && !$past(go_o)) |-> $past(&up_i));
    // R5
    go_idle_after_rows_chk: assert property (@(posedge clk) disable iff (rst)
        (!go_o && $past(go_o)) |-> $past(~|up_i));

endmodule

// File: rtl/bar_tree.sv
module bar_tree
    import bar_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int NCORE = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] arrive_i,
    output logic [NCORE-1:0] release_o
);

    logic [ROWS-1:0] row_up;
    logic            go;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        bar_row #(.COLS(COLS)) row_i (
            .clk    (clk),
            .rst    (rst),
            .arv_i  (arrive_i[r*COLS +: COLS]),
            .go_i   (go),
            .done_o (row_up[r]),
            .rel_o  (release_o[r*COLS +: COLS])
        );
    end

    bar_top_unit #(.ROWS(ROWS)) top_i (
        .clk  (clk),
        .rst  (rst),
        .up_i (row_up),
        .go_o (go)
    );

    // R3
    all_release_together_chk: assert property (@(posedge clk) disable iff (rst)
        (|(release_o & ~$past(release_o))) |-> (&release_o));

endmodule

// File: tb/bar_tree_tb_top.sv
module bar_tree_tb_top;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] rel;

    int n_chk  = 0;
    int n_fail = 0;
    bit run_done = 1'b0;

    always #2.5 clk = ~clk;

    bar_tree dut_i (
        .clk       (clk),
        .rst       (rst),
        .arrive_i  (req),
        .release_o (rel)
    );

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural timing model of barrier episodes
    logic [N-1:0] m_got, m_rel;
    bit m_arm, m_released;
    int m_rcd, m_acd;

    always @(posedge clk) begin
        if (rst) begin
            m_got = '0; m_rel = '0; m_arm = 1'b1; m_released = 1'b0;
            m_rcd = 0; m_acd = 0;
        end else begin
            if (m_arm) m_got = m_got | req;
            if (m_acd > 0) begin
                m_acd--;
                if (m_acd == 0) m_arm = 1'b1;
            end
            m_rel = m_rel & req;
            if (m_released && m_rel == '0) begin
                m_released = 1'b0;
                m_acd = 3;
            end
            if (m_rcd > 0) begin
                m_rcd--;
                if (m_rcd == 0) begin
                    m_rel = '1; m_got = '0; m_arm = 1'b0; m_released = 1'b1;
                end
            end else if (m_arm && (&m_got)) begin
                m_rcd = 3;
            end
        end
    end

    // Per-cycle comparison against the model (R2 R3 R4 R5)
    always @(negedge clk) begin
        if (!rst && !run_done)
            chk(rel === m_rel, "R2 R3 R4 R5 model", rel, m_rel);
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    int wcnt [N];
    int hcnt [N];
    logic [15:0] lfsr = 16'hACE1;
    int eps = 0;
    logic prev0 = 1'b0;

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk(rel === '0, "R1 reset", rel, '0);

        // All cores arrive together
        req = '1;
        for (int k = 0; k < 3; k++) begin
            step(1);
            chk(rel === '0, "R2 early", rel, '0);
        end
        step(1);
        chk(rel === '1, "R3 latency", rel, '1);
        req = '0;
        step(1);
        chk(rel === '0, "R4 ack", rel, '0);
        // Arrival held across the re-arm point
        step(2);
        req = '1;
        step(4);
        chk(rel === '0, "R5 rearm wait", rel, '0);
        step(1);
        chk(rel === '1, "R5 rearm release", rel, '1);

        // Acknowledges one core at a time
        req[3] = 1'b0;
        step(1);
        chk(rel === ~(16'h1 << 3), "R4 single ack", rel, ~(16'h1 << 3));
        req[12] = 1'b0;
        step(1);
        chk(rel === ~(16'h1008), "R4 second ack", rel, ~(16'h1008));
        req = '0;
        step(6);

        // Early re-raise of core 5
        req = '1;
        step(4);
        chk(rel === '1, "R3 episode", rel, '1);
        req[5] = 1'b0;
        step(1);
        req[5] = 1'b1;
        step(1);
        chk(rel === ~(16'h1 << 5), "R6 reraise", rel, ~(16'h1 << 5));
        req = 16'h1 << 5;
        step(1);
        chk(rel === '0, "R6 others ack", rel, '0);
        step(6);
        req = ~(16'h1 << 9);
        for (int k = 0; k < 20; k++) begin
            step(1);
            chk(rel === '0, "R6 waits for core 9", rel, '0);
        end
        req[9] = 1'b1;
        step(3);
        chk(rel === '0, "R6 latency", rel, '0);
        step(1);
        chk(rel === '1, "R6 release", rel, '1);
        req = '0;
        step(6);

        // Staggered arrivals, core 0 last
        for (int i = N - 1; i >= 0; i--) begin
            req[i] = 1'b1;
            step(2);
            chk(rel === '0, "R2 staggered", rel, '0);
        end
        step(1);
        chk(rel === '0, "R2 before last", rel, '0);
        step(1);
        chk(rel === '1, "R3 staggered", rel, '1);
        req = '0;
        step(6);

        // Pseudo-random back-to-back episodes
        for (int i = 0; i < N; i++) begin
            wcnt[i] = i % 5;
            hcnt[i] = 0;
        end
        for (int cyc = 0; cyc < 4000; cyc++) begin
            step(1);
            if (rel[0] && !prev0) eps++;
            prev0 = rel[0];
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (!req[i]) begin
                    if (wcnt[i] == 0) begin
                        req[i] = 1'b1;
                        hcnt[i] = int'(lfsr[1:0]);
                    end else begin
                        wcnt[i]--;
                    end
                end else if (rel[i]) begin
                    if (hcnt[i] == 0) begin
                        req[i] = 1'b0;
                        wcnt[i] = int'(lfsr[4:2]);
                    end else begin
                        hcnt[i]--;
                    end
                end
            end
        end
        chk(eps >= 20, "R5 episodes", 16'(eps), 16'd20);
        req = '0;
        step(8);
        chk(rel === '0, "R4 final idle", rel, '0);

        run_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule